// File: doc/BRIEF.md
# Audio Serial Port Master Clock Generator

This block derives the bit clock and the frame clock of an audio serial port that runs as clock master. Both come from one fast master clock: a first divider sets the bit clock period in master cycles, and a second divider, clocked by the first, counts bit clocks per frame. In two-channel mode the frame clock is a level with a 50% duty cycle that marks the left and right halves of the frame. In multi-slot mode it is a sync pulse one bit clock wide that opens each frame.

A single 32-bit configuration word is loaded through a one-cycle write strobe. It holds the enable, the mode select and both divider values. While the block is idle, an enabling write starts the clocks at once. While it is running, a new word waits until the current frame ends, so no clock pulse is shortened. A write with the enable clear stops everything on the next cycle.

Besides the clock levels, the block gives a downstream serializer one-cycle strobes in the master clock domain. These mark the bit clock rising and falling edges and the first master cycle of each frame.

Top module: `aud_clkgen`

## Requirements
- R1: A write whose bit 0 is 0 clears every output (bclk, fclk and all strobes) on the next cycle and drops any pending word; with bit 0 clear the outputs stay low.
- R2: The bit clock divider D sits in bits 23:11. The bit clock starts low and then toggles every floor(D/2) master cycles.
- R3: A bit clock divider of 0 or 1 acts as 2, so the bit clock toggles on every master cycle; an odd divider rounds its half period down.
- R4: The frame divider F in bits 10:2 gives the number of bit clocks per frame; a value of 0 or 1 acts as 2.
- R5: With bit 1 at 0 (two-channel framing), fclk is low for the first floor(F/2) bit clocks of the frame and high for the rest, and it changes only where the bit clock falls.
- R6: With bit 1 at 1 (multi-slot framing), fclk is high during the first bit clock of each frame only.
- R7: An enabling write made while running is held and takes effect at the next frame boundary; a later write made before that boundary replaces it.
- R8: An enabling write made while idle starts the clocks in the next cycle, with bclk low and a new frame.
- R9: bclk_rise and bclk_fall pulse for one cycle, in the cycle where bclk has just become high or low; no fall strobe is given when the clocks start.
- R10: frame_start pulses for one cycle in the first master cycle of each frame, including the first frame after start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Load strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word (enable, mode, frame divider, bit divider) |
| bclk | output | 1 | Bit clock level |
| fclk | output | 1 | Frame clock level or frame sync |
| bclk_rise | output | 1 | Strobe in the cycle bclk has just risen |
| bclk_fall | output | 1 | Strobe in the cycle bclk has just fallen |
| frame_start | output | 1 | Strobe in the first cycle of each frame |

## Verification
Even dividers in two-channel mode test the basic half-period and the left/right split. An odd bit divider with an odd frame length tests the floor rounding of both fields. Zero divider fields test the treat-as-2 clamps. Multi-slot mode with a short frame tells the one-bit sync pulse apart from the 50% level.

Mid-frame reconfiguration, including two writes before one boundary, tests the hold until the frame boundary and the replacement of a pending word. Realistic audio settings at 16-bit and 32-bit frame sizes test long counts. A mid-frame disable tests that the stop takes effect at once.

// File: rtl/aud_clk_pkg.sv
package aud_clk_pkg;
    localparam int CFG_W  = 32;
    localparam int FR_W   = 9;
    localparam int BD_W   = 13;
    localparam int HALF_W = BD_W - 1;
    localparam int USED_W = 2 + FR_W + BD_W;

    // Field order matches the word: enable in bit 0, mode in bit 1,
    // frame divider above it, bit divider on top.
    typedef struct packed {
        logic [BD_W-1:0] bdiv;
        logic [FR_W-1:0] fdiv;
        logic            tdm;
        logic            en;
    } cfg_t;

    function automatic logic [HALF_W-1:0] half_of(input logic [BD_W-1:0] d);
        if (d < BD_W'(2)) return HALF_W'(1);
        return d[BD_W-1:1];
    endfunction

    function automatic logic [FR_W-1:0] frame_of(input logic [FR_W-1:0] f);
        if (f < FR_W'(2)) return FR_W'(2);
        return f;
    endfunction
endpackage

// File: rtl/aud_cfg_ctrl.sv
module aud_cfg_ctrl
    import aud_clk_pkg::*;
#(
    parameter int WORD_W = CFG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              wrap_now,
    output cfg_t              act_q,
    output logic              tdm_nx,
    output logic              start_now,
    output logic              stop_now
);
    typedef struct packed {
        cfg_t act;
        cfg_t pend;
        logic pend_v;
    } st_t;

    st_t  s_d, s_q;
    cfg_t wcfg;
    logic unused_hi;

    assign wcfg      = cfg_t'(cfg_wdata[USED_W-1:0]);
    assign unused_hi = ^cfg_wdata[WORD_W-1:USED_W];

    always_comb begin
        s_d       = s_q;
        start_now = cfg_we && wcfg.en && !s_q.act.en;
        stop_now  = cfg_we && !wcfg.en;
        if (stop_now) begin
            s_d.act    = '0;
            s_d.pend   = '0;
            s_d.pend_v = 1'b0;
        end else if (start_now) begin
            s_d.act = wcfg;
        end else begin
            if (wrap_now && s_q.pend_v) begin
                s_d.act    = s_q.pend;
                s_d.pend_v = 1'b0;
            end
            if (cfg_we) begin
                s_d.pend   = wcfg;
                s_d.pend_v = 1'b1;
            end
        end
        tdm_nx = s_d.act.tdm;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign act_q = s_q.act;
endmodule

// File: rtl/aud_bit_timer.sv
module aud_bit_timer #(
    parameter int HW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          stop_now,
    input  logic [HW-1:0] half,
    output logic          bclk,
    output logic          rise,
    output logic          fall,
    output logic          fall_now
);
    typedef struct packed {
        logic [HW-1:0] hcnt;
        logic          bclk;
        logic          rise;
        logic          fall;
    } st_t;

    st_t  s_d, s_q;
    logic tick;

    always_comb begin
        tick     = run && !stop_now && (s_q.hcnt == half - 1'b1);
        fall_now = tick && s_q.bclk;
        s_d      = s_q;
        s_d.rise = 1'b0;
        s_d.fall = 1'b0;
        if (stop_now || !run) begin
            s_d = '0;
        end else if (tick) begin
            s_d.hcnt = '0;
            s_d.bclk = !s_q.bclk;
            s_d.rise = !s_q.bclk;
            s_d.fall = s_q.bclk;
        end else begin
            s_d.hcnt = s_q.hcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bclk = s_q.bclk;
    assign rise = s_q.rise;
    assign fall = s_q.fall;
endmodule

// File: rtl/aud_frame_timer.sv
module aud_frame_timer #(
    parameter int FW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          start_now,
    input  logic          stop_now,
    input  logic          fall_now,
    input  logic [FW-1:0] flen,
    input  logic          tdm,
    input  logic          tdm_nx,
    output logic          fclk,
    output logic          fstart,
    output logic          wrap_now
);
    typedef struct packed {
        logic [FW-1:0] bitcnt;
        logic          fclk;
        logic          fstart;
    } st_t;

    st_t           s_d, s_q;
    logic [FW-1:0] nxt;

    always_comb begin
        wrap_now   = fall_now && (s_q.bitcnt == flen - 1'b1);
        nxt        = s_q.bitcnt + 1'b1;
        s_d        = s_q;
        s_d.fstart = 1'b0;
        if (stop_now || (!run && !start_now)) begin
            s_d = '0;
        end else if (start_now || wrap_now) begin
            s_d.bitcnt = '0;
            s_d.fstart = 1'b1;
            s_d.fclk   = tdm_nx;
        end else if (fall_now) begin
            s_d.bitcnt = nxt;
            s_d.fclk   = tdm ? 1'b0 : (nxt >= (flen >> 1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fclk   = s_q.fclk;
    assign fstart = s_q.fstart;
endmodule

// File: rtl/aud_clkgen.sv
module aud_clkgen
    import aud_clk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             bclk,
    output logic             fclk,
    output logic             bclk_rise,
    output logic             bclk_fall,
    output logic             frame_start
);
    cfg_t              act_q;
    logic              tdm_nx, start_now, stop_now, wrap_now, fall_now;
    logic [HALF_W-1:0] half;
    logic [FR_W-1:0]   flen;

    assign half = half_of(act_q.bdiv);
    assign flen = frame_of(act_q.fdiv);

    aud_cfg_ctrl #(.WORD_W(CFG_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .wrap_now(wrap_now), .act_q(act_q), .tdm_nx(tdm_nx),
        .start_now(start_now), .stop_now(stop_now)
    );

    aud_bit_timer #(.HW(HALF_W)) u_bit (
        .clk(clk), .rst_n(rst_n), .run(act_q.en), .stop_now(stop_now),
        .half(half), .bclk(bclk), .rise(bclk_rise), .fall(bclk_fall),
        .fall_now(fall_now)
    );

    aud_frame_timer #(.FW(FR_W)) u_frm (
        .clk(clk), .rst_n(rst_n), .run(act_q.en), .start_now(start_now),
        .stop_now(stop_now), .fall_now(fall_now), .flen(flen),
        .tdm(act_q.tdm), .tdm_nx(tdm_nx), .fclk(fclk),
        .fstart(frame_start), .wrap_now(wrap_now)
    );
endmodule

// File: rtl/aud_clkgen_chk.sv
module aud_clkgen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [31:0] cfg_wdata,
    input logic        bclk,
    input logic        fclk,
    input logic        bclk_rise,
    input logic        bclk_fall,
    input logic        frame_start
);
    a_r9_rise_high: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_rise |-> bclk);
    a_r9_fall_low: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_fall |-> !bclk);
    a_r9_rise_seen: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk && !$past(bclk)) |-> bclk_rise);
    a_r9_one_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bclk_rise, bclk_fall}));
    a_r1_stop_now: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_we && !cfg_wdata[0]) |-> (!bclk && !fclk && !frame_start));
    a_r10_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (!bclk && !bclk_rise));
endmodule

bind aud_clkgen aud_clkgen_chk u_chk (.*);

// File: tb/sim_aud_clkgen.sv
module sim_aud_clkgen;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        bclk, fclk, bclk_rise, bclk_fall, frame_start;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_tag = "R1";

    aud_clkgen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .bclk(bclk), .fclk(fclk), .bclk_rise(bclk_rise),
        .bclk_fall(bclk_fall), .frame_start(frame_start)
    );

    always #(CLK_NS/2) clk = !clk;

    function automatic logic [31:0] mk(input bit en, input bit tdm,
                                       input int fdiv, input int bdiv);
        logic [31:0] w;
        w        = '0;
        w[0]     = en;
        w[1]     = tdm;
        w[10:2]  = fdiv[8:0];
        w[23:11] = bdiv[12:0];
        return w;
    endfunction

    // behavioural model: position within the frame in master cycles
    int          m_run, m_tdm, m_F, m_H, m_pos, m_fresh, p_v;
    logic [31:0] p_w;

    task automatic m_load(input logic [31:0] w);
        int f, b;
        f     = int'(w[10:2]);
        b     = int'(w[23:11]);
        m_tdm = int'(w[1]);
        m_F   = (f < 2) ? 2 : f;
        m_H   = (b < 2) ? 1 : b / 2;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_pos = 0; m_fresh = 0; p_v = 0; p_w = '0;
            m_tdm = 0; m_F = 2; m_H = 1;
        end else begin
            m_fresh = 0;
            if (cfg_we && !cfg_wdata[0]) begin
                m_run = 0; p_v = 0;
            end else if (cfg_we && m_run == 0) begin
                m_load(cfg_wdata); m_run = 1; m_pos = 0; m_fresh = 1;
            end else begin
                if (m_run != 0) begin
                    m_pos++;
                    if (m_pos == m_F * 2 * m_H) begin
                        m_pos = 0;
                        if (p_v != 0) begin m_load(p_w); p_v = 0; end
                    end
                end
                if (cfg_we) begin p_w = cfg_wdata; p_v = 1; end
            end
        end
    end

    task automatic chk(input string req, input string name,
                       input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s case) %s actual %0d expected %0d at %0t",
                     req, cur_tag, name, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            int  ph, bitn;
            logic e_b, e_f, e_r, e_fa, e_s;
            if (m_run == 0) begin
                e_b = 0; e_f = 0; e_r = 0; e_fa = 0; e_s = 0;
            end else begin
                ph   = m_pos % (2 * m_H);
                bitn = m_pos / (2 * m_H);
                e_b  = (ph >= m_H);
                e_r  = (ph == m_H);
                e_fa = (ph == 0) && (m_fresh == 0);
                e_s  = (m_pos == 0);
                e_f  = (m_tdm != 0) ? (bitn == 0) : (bitn >= m_F / 2);
            end
            if (m_run == 0) begin
                chk("R1", "bclk", bclk, e_b);
                chk("R1", "fclk", fclk, e_f);
                chk("R1", "strobes", bclk_rise | bclk_fall | frame_start, 1'b0);
            end else begin
                chk("R2", "bclk", bclk, e_b);
                chk((m_tdm != 0) ? "R6" : "R5", "fclk", fclk, e_f);
                chk("R9", "bclk_rise", bclk_rise, e_r);
                chk("R9", "bclk_fall", bclk_fall, e_fa);
                chk("R10", "frame_start", frame_start, e_s);
            end
        end
    end

    task automatic wr(input logic [31:0] w);
        cfg_we    = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_we    = 1'b0;
        cfg_wdata = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_NS * 200000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle(3);
        chk("R1", "reset bclk", bclk, 1'b0);
        chk("R1", "reset fclk", fclk, 1'b0);
        chk("R1", "reset strobes", bclk_rise | bclk_fall | frame_start, 1'b0);
        rst_n = 1'b1;
        idle(5);

        cur_tag = "R1"; wr(mk(0, 0, 8, 8)); idle(10);   // disabled write stays idle
        cur_tag = "R8"; wr(mk(1, 0, 8, 8)); idle(30);
        cur_tag = "R5"; idle(200);
        cur_tag = "R7"; wr(mk(1, 1, 6, 4)); idle(40);   // held until boundary
        cur_tag = "R6"; idle(150);
        cur_tag = "R7"; wr(mk(1, 0, 4, 2)); idle(3);
        wr(mk(1, 0, 0, 1)); idle(60);                   // second write replaces first
        cur_tag = "R3"; idle(40);
        cur_tag = "R4"; wr(mk(1, 1, 1, 0)); idle(40);
        cur_tag = "R3"; wr(mk(1, 0, 5, 7)); idle(200);  // odd dividers
        cur_tag = "R1"; wr(mk(0, 1, 5, 7)); idle(30);   // disable mid-frame
        cur_tag = "R8"; wr(mk(1, 1, 5, 6)); idle(100);
        cur_tag = "R1"; wr(mk(0, 0, 0, 0)); idle(10);
        cur_tag = "R2"; wr(mk(1, 0, 32, 128)); idle(8300);
        cur_tag = "R7"; wr(mk(1, 0, 64, 64)); idle(8300);
        cur_tag = "R6"; wr(mk(1, 1, 64, 64)); idle(4200);
        cur_tag = "R1"; wr(mk(0, 0, 0, 0)); idle(20);
        finish_run();
    end
endmodule